// File: doc/BRIEF.md
# Operand Capture and Address Former

This block sits beside the instruction sequencer of an 8-bit processor core. It keeps the one or two bytes that follow an opcode in two operand registers, a first (low) byte and a second (high) byte. Each time the first byte is captured, the second register is filled with copies of that byte's top bit in the same edge. A one-byte branch offset therefore already reads as a signed 16-bit quantity. A later capture of the real second byte replaces those fill bits.

The sequencer selects an addressing mode. From the held operands, the current program counter and the two index registers, the block forms three things. The first is a 16-bit effective address. The second is an immediate byte for the ALU path. The third, when a program-counter transfer is requested, is a new program-counter value that is presented one cycle later together with a load strobe. A two-state machine (`XF_IDLE`, `XF_LOAD`) owns that strobe. A valid transfer request in either state moves the machine to `XF_LOAD`. A cycle without one moves it to `XF_IDLE`.

Top module: `opnd_addr_former`

## Requirements
- R1: On a clock edge with `ld_first` high, the first operand register takes `opnd_byte`.
- R2: On that same edge, the second operand register takes all ones if `opnd_byte[7]` is 1 and all zeros otherwise. When `ld_first` and `ld_second` are both high, `ld_first` wins and the second register gets this fill.
- R3: On an edge with `ld_second` high and `ld_first` low, the second operand register takes `opnd_byte` and the first register is unchanged.
- R4: `amode` encodes 0 immediate, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 relative. In mode 4, `ea_out` is {second, first}. In modes 5 and 6 it is {second, first} plus `idx_x` or `idx_y` respectively, modulo 2^16.
- R5: In modes 1 to 3, `ea_out[15:8]` is 0 regardless of the second register. In mode 1, `ea_out[7:0]` is the first operand. In modes 2 and 3 it is the first operand plus `idx_x` or `idx_y`, modulo 256.
- R6: `imm_out` equals the first operand in mode 0 and is 0 in every other mode. `ea_out` is 0 in mode 0.
- R7: In mode 7, `ea_out` is `pc_cur` plus the signed offset {second, first}, modulo 2^16. `pc_cur` is the address of the byte after the branch.
- R8: An edge with `xfer_req` high in mode 4 gives `pc_load` = 1 and `pc_next` = {second, first} in the following cycle. The operand values used are those held before that edge, even if an operand load happens on the same edge.
- R9: An edge with `xfer_req` high in mode 7 gives `pc_load` = 1 and `pc_next` = `pc_cur` + {second, first} (modulo 2^16, both sampled at that edge) in the following cycle.
- R10: An edge with `xfer_req` low, or with any mode other than 4 or 7, gives `pc_load` = 0 in the following cycle and leaves `pc_next` unchanged.
- R11: A synchronous reset (`rst` high at an edge) clears both operand registers and `pc_next` to 0, deasserts `pc_load` and returns the machine to `XF_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opnd_byte | input | 8 | Operand byte from the data bus |
| ld_first | input | 1 | Capture strobe for the first operand |
| ld_second | input | 1 | Capture strobe for the second operand |
| amode | input | 3 | Addressing-mode select (encoding in R4) |
| xfer_req | input | 1 | Program-counter transfer request |
| pc_cur | input | 16 | Current program counter |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| ea_out | output | 16 | Effective address |
| pc_next | output | 16 | Program-counter load value |
| pc_load | output | 1 | Program-counter load strobe |
| imm_out | output | 8 | Immediate byte for the ALU path |

## Verification
Operand capture and program-counter transfer can fall on the same edge. The transfer must use the operands held before the edge, while the new byte and its sign fill must appear only in the effective address after the edge. The bench provokes this by raising `ld_first` together with `xfer_req` in absolute mode. It then compares `pc_next` against the old operand pair and `ea_out` against the new one. A second case raises both load strobes at once, and the result is judged against the sign-fill rule.

// File: rtl/oaf_pkg.sv
package oaf_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        AM_IMM  = 3'd0,
        AM_ZP   = 3'd1,
        AM_ZPX  = 3'd2,
        AM_ZPY  = 3'd3,
        AM_ABS  = 3'd4,
        AM_ABSX = 3'd5,
        AM_ABSY = 3'd6,
        AM_REL  = 3'd7
    } amode_e;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_LOAD = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/oaf_operand_regs.sv
module oaf_operand_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opnd_byte,
    input  logic          ld_first,
    input  logic          ld_second,
    output logic [DW-1:0] op_lo,
    output logic [DW-1:0] op_hi
);

    logic [DW-1:0] fill;

    always_comb begin
        fill = {DW{opnd_byte[DW-1]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_lo <= '0;
            op_hi <= '0;
        end else if (ld_first) begin
            op_lo <= opnd_byte;
            op_hi <= fill;
        end else if (ld_second) begin
            op_hi <= opnd_byte;
        end
    end

endmodule

// File: rtl/oaf_addr_calc.sv
module oaf_addr_calc
    import oaf_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [2:0]    amode,
    input  logic [DW-1:0] op_lo,
    input  logic [DW-1:0] op_hi,
    input  logic [AW-1:0] pc_cur,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    output logic [AW-1:0] ea_out,
    output logic [DW-1:0] imm_out,
    output logic [AW-1:0] abs_target,
    output logic [AW-1:0] rel_target
);

    amode_e        mode_q;
    logic [DW-1:0] idx_sel;
    logic [DW-1:0] zp_sum;
    logic [AW-1:0] abs_sum;
    logic [AW-1:0] opnd_word;

    always_comb begin
        mode_q    = amode_e'(amode);
        opnd_word = {op_hi, op_lo};
        idx_sel   = ((mode_q == AM_ZPY) || (mode_q == AM_ABSY)) ? idx_y : idx_x;
        zp_sum    = op_lo + idx_sel;
        abs_sum   = opnd_word + {{DW{1'b0}}, idx_sel};
        abs_target = opnd_word;
        rel_target = pc_cur + opnd_word;
    end

    always_comb begin
        imm_out = '0;
        ea_out  = '0;
        unique case (mode_q)
            AM_IMM:  imm_out = op_lo;
            AM_ZP:   ea_out  = {{DW{1'b0}}, op_lo};
            AM_ZPX,
            AM_ZPY:  ea_out  = {{DW{1'b0}}, zp_sum};
            AM_ABS:  ea_out  = opnd_word;
            AM_ABSX,
            AM_ABSY: ea_out  = abs_sum;
            AM_REL:  ea_out  = rel_target;
        endcase
    end

endmodule

// File: rtl/oaf_pc_xfer.sv
module oaf_pc_xfer
    import oaf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_req,
    input  logic [2:0]    amode,
    input  logic [AW-1:0] abs_target,
    input  logic [AW-1:0] rel_target,
    output logic          pc_load,
    output logic [AW-1:0] pc_next
);

    xfer_state_e state_q;
    xfer_state_e state_d;
    logic        is_abs;
    logic        is_rel;
    logic        req_ok;

    always_comb begin
        is_abs = (amode_e'(amode) == AM_ABS);
        is_rel = (amode_e'(amode) == AM_REL);
        req_ok = xfer_req && (is_abs || is_rel);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: state_d = req_ok ? XF_LOAD : XF_IDLE;
            XF_LOAD: state_d = req_ok ? XF_LOAD : XF_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // load value register, written only when a transfer is accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_next <= '0;
        end else if (req_ok) begin
            pc_next <= is_rel ? rel_target : abs_target;
        end
    end

    // outputs
    always_comb begin
        pc_load = (state_q == XF_LOAD);
    end

endmodule

// File: rtl/opnd_addr_former.sv
module opnd_addr_former #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opnd_byte,
    input  logic          ld_first,
    input  logic          ld_second,
    input  logic [2:0]    amode,
    input  logic          xfer_req,
    input  logic [AW-1:0] pc_cur,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    output logic [AW-1:0] ea_out,
    output logic [AW-1:0] pc_next,
    output logic          pc_load,
    output logic [DW-1:0] imm_out
);

    logic [DW-1:0] op_lo_q;
    logic [DW-1:0] op_hi_q;
    logic [AW-1:0] abs_target;
    logic [AW-1:0] rel_target;

    oaf_operand_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .opnd_byte (opnd_byte),
        .ld_first  (ld_first),
        .ld_second (ld_second),
        .op_lo     (op_lo_q),
        .op_hi     (op_hi_q)
    );

    oaf_addr_calc #(.DW(DW)) u_calc (
        .amode      (amode),
        .op_lo      (op_lo_q),
        .op_hi      (op_hi_q),
        .pc_cur     (pc_cur),
        .idx_x      (idx_x),
        .idx_y      (idx_y),
        .ea_out     (ea_out),
        .imm_out    (imm_out),
        .abs_target (abs_target),
        .rel_target (rel_target)
    );

    oaf_pc_xfer #(.AW(AW)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .xfer_req   (xfer_req),
        .amode      (amode),
        .abs_target (abs_target),
        .rel_target (rel_target),
        .pc_load    (pc_load),
        .pc_next    (pc_next)
    );

endmodule

// File: rtl/oaf_checker.sv
module oaf_checker #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] opnd_byte,
    input logic          ld_first,
    input logic          ld_second,
    input logic [2:0]    amode,
    input logic          xfer_req,
    input logic [AW-1:0] pc_cur,
    input logic [DW-1:0] op_lo,
    input logic [DW-1:0] op_hi,
    input logic [AW-1:0] ea_out,
    input logic [AW-1:0] pc_next,
    input logic          pc_load
);

    a_r1_first_capture: assert property (@(posedge clk) disable iff (rst)
        ld_first |=> op_lo == $past(opnd_byte));

    a_r2_sign_fill: assert property (@(posedge clk) disable iff (rst)
        ld_first |=> op_hi == {DW{$past(opnd_byte[DW-1])}});

    a_r3_second_capture: assert property (@(posedge clk) disable iff (rst)
        (ld_second && !ld_first) |=> (op_hi == $past(opnd_byte)) && $stable(op_lo));

    a_r5_page_zero: assert property (@(posedge clk) disable iff (rst)
        (amode == 3'd1 || amode == 3'd2 || amode == 3'd3) |-> ea_out[AW-1:DW] == '0);

    a_r8_jump_value: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && amode == 3'd4) |=> pc_load && (pc_next == $past({op_hi, op_lo})));

    a_r9_branch_value: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && amode == 3'd7) |=> pc_load && (pc_next == $past(pc_cur + {op_hi, op_lo})));

    a_r10_no_transfer: assert property (@(posedge clk) disable iff (rst)
        !(xfer_req && (amode == 3'd4 || amode == 3'd7)) |=> !pc_load && $stable(pc_next));

    a_r11_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> !pc_load && op_lo == '0 && op_hi == '0 && pc_next == '0);

endmodule

bind opnd_addr_former oaf_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .opnd_byte (opnd_byte),
    .ld_first  (ld_first),
    .ld_second (ld_second),
    .amode     (amode),
    .xfer_req  (xfer_req),
    .pc_cur    (pc_cur),
    .op_lo     (op_lo_q),
    .op_hi     (op_hi_q),
    .ea_out    (ea_out),
    .pc_next   (pc_next),
    .pc_load   (pc_load)
);

// File: tb/opnd_addr_former_bench.sv
`timescale 1ns/1ps
module opnd_addr_former_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  opnd_byte;
    logic        ld_first;
    logic        ld_second;
    logic [2:0]  amode;
    logic        xfer_req;
    logic [15:0] pc_cur;
    logic [7:0]  idx_x;
    logic [7:0]  idx_y;
    logic [15:0] ea_out;
    logic [15:0] pc_next;
    logic        pc_load;
    logic [7:0]  imm_out;

    always #10 clk = ~clk;

    opnd_addr_former u_opnd_addr_former (
        .clk       (clk),
        .rst       (rst),
        .opnd_byte (opnd_byte),
        .ld_first  (ld_first),
        .ld_second (ld_second),
        .amode     (amode),
        .xfer_req  (xfer_req),
        .pc_cur    (pc_cur),
        .idx_x     (idx_x),
        .idx_y     (idx_y),
        .ea_out    (ea_out),
        .pc_next   (pc_next),
        .pc_load   (pc_load),
        .imm_out   (imm_out)
    );

    typedef struct packed {
        logic [15:0] ea;
        logic [15:0] pcv;
        logic        pcl;
        logic [7:0]  imm;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    // reference state
    logic [7:0]  m_lo = 8'h00;
    logic [7:0]  m_hi = 8'h00;
    logic [15:0] m_pcv = 16'h0000;

    function automatic logic [15:0] model_ea(input logic [2:0] m, input logic [7:0] lo,
                                             input logic [7:0] hi, input logic [15:0] pc,
                                             input logic [7:0] x, input logic [7:0] y);
        logic [7:0] zs;
        case (m)
            3'd1: return {8'h00, lo};
            3'd2: begin zs = lo + x; return {8'h00, zs}; end
            3'd3: begin zs = lo + y; return {8'h00, zs}; end
            3'd4: return {hi, lo};
            3'd5: return {hi, lo} + {8'h00, x};
            3'd6: return {hi, lo} + {8'h00, y};
            3'd7: return pc + {hi, lo};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic step(input bit r, input bit l1, input bit l2, input logic [7:0] d,
                        input logic [2:0] m, input bit t, input logic [15:0] pc,
                        input logic [7:0] x, input logic [7:0] y, input string tag);
        exp_t e;
        logic [7:0] n_lo;
        logic [7:0] n_hi;
        @(negedge clk);
        rst = r; ld_first = l1; ld_second = l2; opnd_byte = d;
        amode = m; xfer_req = t; pc_cur = pc; idx_x = x; idx_y = y;
        n_lo = m_lo; n_hi = m_hi;
        if (r) begin
            n_lo = 8'h00; n_hi = 8'h00; m_pcv = 16'h0000; e.pcl = 1'b0;
        end else begin
            if (l1) begin n_lo = d; n_hi = {8{d[7]}}; end
            else if (l2) n_hi = d;
            e.pcl = 1'b0;
            if (t && m == 3'd4) begin e.pcl = 1'b1; m_pcv = {m_hi, m_lo}; end
            if (t && m == 3'd7) begin e.pcl = 1'b1; m_pcv = pc + {m_hi, m_lo}; end
        end
        e.pcv = m_pcv;
        e.ea  = model_ea(m, n_lo, n_hi, pc, x, y);
        e.imm = (m == 3'd0) ? n_lo : 8'h00;
        m_lo = n_lo; m_hi = n_hi;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic cmp(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                cmp(tg, "ea_out",  ea_out,           e.ea);
                cmp(tg, "pc_next", pc_next,          e.pcv);
                cmp(tg, "pc_load", {15'd0, pc_load}, {15'd0, e.pcl});
                cmp(tg, "imm_out", {8'd0, imm_out},  {8'd0, e.imm});
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ld_first = 1'b0; ld_second = 1'b0; opnd_byte = 8'h00;
        amode = 3'd0; xfer_req = 1'b0; pc_cur = 16'h0000; idx_x = 8'h00; idx_y = 8'h00;
        repeat (3) @(posedge clk);
        // R11 reset state
        step(1, 0, 0, 8'hAA, 3'd0, 1, 16'h1234, 8'h00, 8'h00, "R11 reset");
        // R1 R6 immediate capture
        step(0, 1, 0, 8'h34, 3'd0, 0, 16'h0000, 8'h00, 8'h00, "R1/R6 imm");
        // R2 negative byte fills high register, R5 zero page ignores it
        step(0, 1, 0, 8'h85, 3'd1, 0, 16'h0000, 8'h00, 8'h00, "R2/R5 zp");
        // R3 second byte replaces fill, R4 absolute
        step(0, 0, 1, 8'h12, 3'd4, 0, 16'h0000, 8'h00, 8'h00, "R3/R4 abs");
        step(0, 0, 0, 8'h00, 3'd5, 0, 16'h0000, 8'h80, 8'h00, "R4 absx");
        step(0, 0, 0, 8'h00, 3'd6, 0, 16'h0000, 8'h00, 8'h7B, "R4 absy");
        step(0, 0, 0, 8'h00, 3'd2, 0, 16'h0000, 8'h90, 8'h00, "R5 zpx wrap");
        step(0, 0, 0, 8'h00, 3'd3, 0, 16'h0000, 8'h00, 8'h7B, "R5 zpy wrap");
        step(0, 0, 0, 8'h00, 3'd0, 0, 16'h0000, 8'h00, 8'h00, "R6 imm");
        // R8 jump while first operand is reloaded on the same edge
        step(0, 1, 0, 8'hF0, 3'd4, 1, 16'h0000, 8'h00, 8'h00, "R8 jump+load");
        step(0, 0, 0, 8'h00, 3'd4, 0, 16'h0000, 8'h00, 8'h00, "R10 no req");
        step(0, 0, 0, 8'h00, 3'd1, 1, 16'h0000, 8'h00, 8'h00, "R10 zp req");
        // R7 R9 backward branch, back to back
        step(0, 0, 0, 8'h00, 3'd7, 1, 16'h2005, 8'h00, 8'h00, "R7/R9 back");
        step(0, 0, 0, 8'h00, 3'd7, 1, 16'h3000, 8'h00, 8'h00, "R9 again");
        step(0, 1, 0, 8'h7F, 3'd7, 0, 16'hFFF0, 8'h00, 8'h00, "R7 fwd wrap");
        step(0, 0, 0, 8'h00, 3'd7, 1, 16'hFFF0, 8'h00, 8'h00, "R9 fwd wrap");
        step(0, 0, 0, 8'h00, 3'd6, 0, 16'h0000, 8'h00, 8'h00, "R10 hold");
        // R2 both strobes on one edge
        step(0, 1, 1, 8'h80, 3'd4, 0, 16'h0000, 8'h00, 8'h00, "R2 both");
        step(0, 0, 1, 8'hFF, 3'd5, 0, 16'h0000, 8'h90, 8'h00, "R4 absx wrap");
        step(0, 0, 0, 8'h00, 3'd4, 1, 16'h0000, 8'h00, 8'h00, "R8 jump");
        step(1, 0, 0, 8'h00, 3'd4, 0, 16'h0000, 8'h00, 8'h00, "R11 reset again");
        step(0, 0, 0, 8'h00, 3'd0, 0, 16'h0000, 8'h00, 8'h00, "R11 after");
        repeat (3) @(posedge clk);
        #5;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule